// File: doc/BRIEF.md
# Serial Pattern Register Bank

This block holds four transmit patterns for a multichannel pulser. Each pattern is made of two halves: one half drives the positive-side switch and the other drives the negative-side switch. For every pattern, bit n of the P half and bit n of the N half together give the drive state for time step n of the output waveform. A playback block reads all four patterns at once through two wide parallel buses.

Patterns are written one at a time through a serial port. The port has a serial clock, a data input, an active-low select and a two-bit pattern address. The addressed pattern behaves as a single chain. New bits enter the P half, move through it into the N half, and the last N bit leaves on a cascade output so that several banks can be chained. A width input sets each half to its full length or to a short length. In short mode the upper bits of both halves are frozen.

Top module: `pattern_reg_bank`

## Requirements
- R1: While `rst_n` is low, every bit of `p_words` and `n_words` is 0 and `casc_out` is 0. This holds again after a reset that arrives in the middle of loading.
- R2: Only the pattern selected by `pat_addr` shifts: code 0 (binary 00) selects pattern 0, code 1 selects pattern 1, code 2 selects pattern 2 and code 3 selects pattern 3. The other three patterns keep their contents.
- R3: While `sel_n` is high, no pattern bit changes on a clock edge, whatever `sdata_in` does.
- R4: Shifting happens only on the rising edge of `sclk`. On that edge the addressed P half takes `sdata_in` into bit 0 and moves each of its bits up by one position. The falling edge changes nothing.
- R5: With `wide_mode` high, P bit 31 feeds N bit 0 and the chain is 64 bits long. The first bit shifted in appears on `casc_out` after 64 rising edges. At that point the N half holds bits 1 to 32 of the stream and the P half holds bits 33 to 64, with the earliest bit of each group at bit 31.
- R6: With `wide_mode` low, P bit 15 feeds N bit 0 and the chain is 32 bits long. Bits 16 to 31 of both halves of every pattern keep their values.
- R7: `casc_out` always shows the last N bit of the addressed pattern for the current width: N bit 31 in wide mode and N bit 15 in short mode. It follows changes of `pat_addr` and `wide_mode` without a clock edge.
- R8: Pattern k appears on `p_words[k*32 +: 32]` and `n_words[k*32 +: 32]`. Bit n of each 32-bit slice is time step n of the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; shifts on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low shift enable |
| pat_addr | input | 2 | Number of the pattern to load |
| wide_mode | input | 1 | 1: 32-bit halves, 0: 16-bit halves |
| sdata_in | input | 1 | Serial data into the P half |
| casc_out | output | 1 | Last N-half bit of the addressed pattern |
| p_words | output | 128 | P halves of all patterns, 32 bits each |
| n_words | output | 128 | N halves of all patterns, 32 bits each |

## Verification
The hardest state to reach from the ports is a pattern whose upper halves hold non-zero data while a short-mode load runs through it. Only then does a wrong tap or a missing freeze on bits 16 to 31 become visible. The bench first fills that pattern completely in wide mode with a dense bit stream. It then reloads the same pattern in short mode and compares the frozen upper bits and the cascade tap against its own model. Loads into neighbouring patterns, and a reset arriving in the middle of a load, cover the address and clear paths.

// File: rtl/pat_bank_pkg.sv
package pat_bank_pkg;

  // Index of the last live bit in a half, given the width select
  function automatic int tap_index(input logic wide, input int half_max, input int half_min);
    return wide ? (half_max - 1) : (half_min - 1);
  endfunction

  // Whether bit position pos takes part in shifting for this width
  function automatic logic bit_live(input logic wide, input int pos, input int half_min);
    return wide || (pos < half_min);
  endfunction

endpackage

// File: rtl/pat_addr_decode.sv
module pat_addr_decode #(
  parameter int NUM_PAT = 4,
  parameter int ADDR_W  = $clog2(NUM_PAT)
) (
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_PAT-1:0] shift_en
);

  for (genvar k = 0; k < NUM_PAT; k++) begin : g_dec
    assign shift_en[k] = !sel_n && (addr == ADDR_W'(k));
  end

endmodule

// File: rtl/pat_half_shreg.sv
module pat_half_shreg
  import pat_bank_pkg::*;
#(
  parameter int HALF_MAX = 32,
  parameter int HALF_MIN = 16
) (
  input  logic                sclk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                wide,
  input  logic                din,
  output logic [HALF_MAX-1:0] q,
  output logic                tail
);

  localparam int TAP_HI = HALF_MAX - 1;
  localparam int TAP_LO = HALF_MIN - 1;

  for (genvar i = 0; i < HALF_MAX; i++) begin : g_bit
    logic nxt;
    if (i == 0) begin : g_head
      assign nxt = din;
    end else begin : g_body
      assign nxt = q[i-1];
    end

    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= 1'b0;
      end else if (en && bit_live(wide, i, HALF_MIN)) begin
        q[i] <= nxt;
      end
    end
  end

  assign tail = (tap_index(wide, HALF_MAX, HALF_MIN) == TAP_HI) ? q[TAP_HI] : q[TAP_LO];

endmodule

// File: rtl/pat_chain.sv
module pat_chain #(
  parameter int HALF_MAX = 32,
  parameter int HALF_MIN = 16
) (
  input  logic                sclk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                wide,
  input  logic                din,
  output logic [HALF_MAX-1:0] p_q,
  output logic [HALF_MAX-1:0] n_q,
  output logic                chain_out
);

  logic p_tail;

  pat_half_shreg #(.HALF_MAX(HALF_MAX), .HALF_MIN(HALF_MIN)) i_p_half (
    .sclk (sclk),
    .rst_n(rst_n),
    .en   (en),
    .wide (wide),
    .din  (din),
    .q    (p_q),
    .tail (p_tail)
  );

  pat_half_shreg #(.HALF_MAX(HALF_MAX), .HALF_MIN(HALF_MIN)) i_n_half (
    .sclk (sclk),
    .rst_n(rst_n),
    .en   (en),
    .wide (wide),
    .din  (p_tail),
    .q    (n_q),
    .tail (chain_out)
  );

endmodule

// File: rtl/pattern_reg_bank.sv
module pattern_reg_bank #(
  parameter int NUM_PAT  = 4,
  parameter int HALF_MAX = 32,
  parameter int HALF_MIN = 16,
  parameter int ADDR_W   = $clog2(NUM_PAT)
) (
  input  logic                         sclk,
  input  logic                         rst_n,
  input  logic                         sel_n,
  input  logic [ADDR_W-1:0]            pat_addr,
  input  logic                         wide_mode,
  input  logic                         sdata_in,
  output logic                         casc_out,
  output logic [NUM_PAT*HALF_MAX-1:0]  p_words,
  output logic [NUM_PAT*HALF_MAX-1:0]  n_words
);

  logic [NUM_PAT-1:0] shift_en;
  logic [NUM_PAT-1:0] chain_tail;

  pat_addr_decode #(.NUM_PAT(NUM_PAT), .ADDR_W(ADDR_W)) i_dec (
    .sel_n   (sel_n),
    .addr    (pat_addr),
    .shift_en(shift_en)
  );

  for (genvar k = 0; k < NUM_PAT; k++) begin : g_pat
    pat_chain #(.HALF_MAX(HALF_MAX), .HALF_MIN(HALF_MIN)) i_chain (
      .sclk     (sclk),
      .rst_n    (rst_n),
      .en       (shift_en[k]),
      .wide     (wide_mode),
      .din      (sdata_in),
      .p_q      (p_words[k*HALF_MAX +: HALF_MAX]),
      .n_q      (n_words[k*HALF_MAX +: HALF_MAX]),
      .chain_out(chain_tail[k])
    );
  end

  assign casc_out = chain_tail[pat_addr];

endmodule

// File: rtl/pattern_reg_bank_chk.sv
module pattern_reg_bank_chk #(
  parameter int NUM_PAT  = 4,
  parameter int HALF_MAX = 32,
  parameter int HALF_MIN = 16,
  parameter int ADDR_W   = $clog2(NUM_PAT)
) (
  input logic                        sclk,
  input logic                        rst_n,
  input logic                        sel_n,
  input logic [ADDR_W-1:0]           pat_addr,
  input logic                        wide_mode,
  input logic                        sdata_in,
  input logic                        casc_out,
  input logic [NUM_PAT*HALF_MAX-1:0] p_words,
  input logic [NUM_PAT*HALF_MAX-1:0] n_words,
  input logic [NUM_PAT-1:0]          shift_en
);

  localparam int UPW = HALF_MAX - HALF_MIN;

  logic [NUM_PAT*UPW*2-1:0] upper_all;
  for (genvar k = 0; k < NUM_PAT; k++) begin : g_up
    assign upper_all[k*2*UPW +: UPW]       = p_words[k*HALF_MAX + HALF_MIN +: UPW];
    assign upper_all[k*2*UPW + UPW +: UPW] = n_words[k*HALF_MAX + HALF_MIN +: UPW];
  end

  logic [ADDR_W-1:0] addr_q;
  logic              din_q;
  logic              shifted_q;
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      din_q     <= 1'b0;
      shifted_q <= 1'b0;
    end else begin
      addr_q    <= pat_addr;
      din_q     <= sdata_in;
      shifted_q <= !sel_n;
    end
  end

  logic p0_last;
  logic n_pre_tail;
  always_comb begin
    p0_last    = p_words[int'(addr_q)*HALF_MAX];
    n_pre_tail = n_words[int'(pat_addr)*HALF_MAX + HALF_MAX - 2];
  end

  always @(posedge sclk) begin
    if (!rst_n) begin
      assert_clear_R1: assert (p_words == '0 && n_words == '0 && casc_out == 1'b0);
    end
  end

  assert_onehot_R2: assert property (@(posedge sclk) disable iff (!rst_n)
    $onehot0(shift_en));

  for (genvar k = 0; k < NUM_PAT; k++) begin : g_keep
    assert_keep_R2: assert property (@(posedge sclk) disable iff (!rst_n)
      !shift_en[k] |=> ($stable(p_words[k*HALF_MAX +: HALF_MAX]) &&
                        $stable(n_words[k*HALF_MAX +: HALF_MAX])));
  end

  assert_idle_R3: assert property (@(posedge sclk) disable iff (!rst_n)
    sel_n |=> ($stable(p_words) && $stable(n_words)));

  assert_head_R4: assert property (@(posedge sclk) disable iff (!rst_n)
    shifted_q |-> (p0_last == din_q));

  assert_casc_R5: assert property (@(posedge sclk) disable iff (!rst_n)
    ($past(rst_n) && $past(!sel_n && wide_mode) && wide_mode &&
     pat_addr == $past(pat_addr)) |-> (casc_out == $past(n_pre_tail)));

  assert_upper_R6: assert property (@(posedge sclk) disable iff (!rst_n)
    !wide_mode |=> $stable(upper_all));

endmodule

bind pattern_reg_bank pattern_reg_bank_chk #(
  .NUM_PAT (NUM_PAT),
  .HALF_MAX(HALF_MAX),
  .HALF_MIN(HALF_MIN),
  .ADDR_W  (ADDR_W)
) i_chk (.*);

// File: tb/test_pattern_reg_bank.sv
module test_pattern_reg_bank;

  logic         sclk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_n = 1'b1;
  logic [1:0]   pat_addr = 2'd0;
  logic         wide_mode = 1'b1;
  logic         sdata_in = 1'b0;
  logic         casc_out;
  logic [127:0] p_words;
  logic [127:0] n_words;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [31:0] mp [4];
  logic [31:0] mn [4];

  always #5 sclk = ~sclk;

  pattern_reg_bank i_pattern_reg_bank (
    .sclk(sclk), .rst_n(rst_n), .sel_n(sel_n), .pat_addr(pat_addr),
    .wide_mode(wide_mode), .sdata_in(sdata_in), .casc_out(casc_out),
    .p_words(p_words), .n_words(n_words)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int last_bit(input logic w);
    return w ? 31 : 15;
  endfunction

  task automatic model_shift(input logic [1:0] a, input logic w, input logic b);
    int t = last_bit(w);
    logic carry = mp[a][t];
    for (int i = t; i > 0; i--) begin
      mn[a][i] = mn[a][i-1];
      mp[a][i] = mp[a][i-1];
    end
    mn[a][0] = carry;
    mp[a][0] = b;
  endtask

  task automatic check_state(input string req);
    for (int k = 0; k < 4; k++) begin
      check(req, {96'd0, p_words[k*32 +: 32]}, {96'd0, mp[k]});
      check(req, {96'd0, n_words[k*32 +: 32]}, {96'd0, mn[k]});
    end
    check(req, {127'd0, casc_out}, {127'd0, mn[pat_addr][last_bit(wide_mode)]});
  endtask

  task automatic shift_one(input logic [1:0] a, input logic w, input logic b);
    pat_addr = a; wide_mode = w; sdata_in = b; sel_n = 1'b0;
    @(posedge sclk);
    model_shift(a, w, b);
    @(negedge sclk);
    sel_n = 1'b1;
  endtask

  task automatic apply_reset;
    rst_n = 1'b0;
    for (int k = 0; k < 4; k++) begin mp[k] = '0; mn[k] = '0; end
    repeat (2) @(negedge sclk);
    check("R1", {p_words, n_words} == '0 ? 128'd0 : 128'd1, 128'd0);
    check("R1", {127'd0, casc_out}, 128'd0);
    rst_n = 1'b1;
    @(negedge sclk);
  endtask

  task automatic t_wide_load;
    logic [63:0] v = 64'hA5C3_0F96_1E2D_7B48;
    for (int i = 0; i < 64; i++) begin
      shift_one(2'd0, 1'b1, v[i]);
      if (i == 62) check("R5", {127'd0, casc_out}, 128'd0);
    end
    check("R5", {127'd0, casc_out}, {127'd0, v[0]});
    for (int j = 0; j < 32; j++) begin
      check("R5", {127'd0, n_words[j]}, {127'd0, v[31-j]});
      check("R8", {127'd0, p_words[j]}, {127'd0, v[63-j]});
    end
    check("R2", p_words[127:32], 96'd0);
    check_state("R8");
  endtask

  task automatic t_narrow_load;
    logic [63:0] pre = 64'h3C96_E1D2_58A7_4BF0;
    logic [31:0] v = 32'hD2B4_6E19;
    logic [15:0] pu, nu;
    for (int i = 0; i < 64; i++) shift_one(2'd2, 1'b1, pre[i]);
    pu = p_words[64+16 +: 16];
    nu = n_words[64+16 +: 16];
    for (int i = 0; i < 32; i++) shift_one(2'd2, 1'b0, v[i]);
    check("R6", {112'd0, p_words[64+16 +: 16]}, {112'd0, pu});
    check("R6", {112'd0, n_words[64+16 +: 16]}, {112'd0, nu});
    check("R6", {127'd0, casc_out}, {127'd0, v[0]});
    for (int j = 0; j < 16; j++)
      check("R6", {127'd0, p_words[64+j]}, {127'd0, v[31-j]});
    check_state("R6");
  endtask

  task automatic t_casc_mux;
    for (int a = 0; a < 4; a++) begin
      pat_addr = 2'(a);
      wide_mode = 1'b1; #1;
      check("R7", {127'd0, casc_out}, {127'd0, mn[a][31]});
      wide_mode = 1'b0; #1;
      check("R7", {127'd0, casc_out}, {127'd0, mn[a][15]});
    end
    @(negedge sclk);
  endtask

  task automatic t_hold;
    pat_addr = 2'd0; wide_mode = 1'b1; sel_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sdata_in = i[0];
      @(negedge sclk);
    end
    check_state("R3");
  endtask

  task automatic t_addr_each;
    for (int a = 0; a < 4; a++) begin
      shift_one(2'(a), 1'b1, 1'b1);
      check_state("R2");
    end
  endtask

  task automatic t_edges;
    logic [127:0] snap;
    pat_addr = 2'd1; wide_mode = 1'b1; sdata_in = 1'b1; sel_n = 1'b0;
    @(posedge sclk);
    model_shift(2'd1, 1'b1, 1'b1);
    #2 snap = p_words;
    check("R4", {127'd0, p_words[32]}, 128'd1);
    sdata_in = 1'b0;
    @(negedge sclk);
    #2;
    check("R4", p_words, snap);
    sel_n = 1'b1;
    @(negedge sclk);
    check_state("R4");
  endtask

  task automatic t_mid_reset;
    for (int i = 0; i < 5; i++) shift_one(2'd3, 1'b1, 1'b1);
    apply_reset();
    check_state("R1");
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    apply_reset();
    check_state("R1");
    t_wide_load();
    t_narrow_load();
    t_casc_mux();
    t_hold();
    t_addr_each();
    t_edges();
    t_mid_reset();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule